// File: doc/BRIEF.md
# Open-Loop Squaring Carrier Recovery

This block regenerates a clean carrier reference from a sampled binary phase-shift keyed signal without any feedback loop. Each signed input sample is squared, which removes the ±1 data modulation and leaves a tone at twice the carrier frequency. A second-order resonator tuned to that doubled frequency isolates the tone. A toggle flip-flop, clocked by the tone's rising zero crossings, halves its frequency into a fixed-level square wave. A second resonator tuned to the carrier turns that square wave back into a sinusoid.

There is no loop to settle, so a burst receiver has a usable reference after a few filter time constants. Resonator coefficients are fixed parameters chosen for the sample rate and carrier. For reliable squaring the sample rate should be at least ten times the carrier. The regenerated carrier may be inverted relative to the transmitter, so the mixer and bit slicer downstream must accept an inverted bit stream.

Top module: `carrier_recovery`

## Requirements
- R1: An active-low reset, applied asynchronously, clears every stage, drives carrier_o to 0 and valid_o to 0, and sets the halver polarity to +LEVEL.
- R2: While en_i is low, no state changes: carrier_o and valid_o keep their values for that cycle.
- R3: On an enabled edge the squarer registers the 32-bit signed product sample_i·sample_i shifted right by 15 (bits 30:15). The single overflow case, input -32768, gives 32767.
- R4: Each resonator computes y = (b0·x[n] + b1·x[n-1] + b2·x[n-2] − a1·y[n-1] − a2·y[n-2]) >>> 14 with Q2.14 coefficients and a 36-bit accumulator. The shift rounds toward minus infinity, and the result saturates to [-32768, 32767].
- R5: The halver output is +LEVEL or −LEVEL. It toggles on an enabled edge only when the previous first-resonator output was negative and the current one is zero or above.
- R6: valid_o rises on the fourth enabled edge after reset and stays high until the next reset.
- R7: With a steady modulated input at the design carrier, carrier_o settles to a sinusoid at the carrier frequency. With the default coefficients at 25 samples per carrier period, it shows 20±2 rising zero crossings per 500 samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clock enable; low stalls the whole pipeline |
| sample_i | input | 16 | Two's complement input sample |
| carrier_o | output | 16 | Recovered carrier, signed |
| valid_o | output | 1 | High once the pipeline holds real data |

## Verification
The bench builds the block with the default resonator coefficients: 4 MHz and 2 MHz centres at a 50 MS/s rate, pole radius 0.97, and a halver level of 16384. At 25 samples per carrier period the carrier frequency can then be checked by counting zero crossings. The lowered level keeps the square wave's fundamental below full scale, so normal operation stays linear. Full-scale inputs of both signs reach the squarer's single overflow case. Injected stall cycles, and a reset applied between clock edges, exercise the hold and asynchronous clear paths.

// File: rtl/carrier_rec_pkg.sv
package carrier_rec_pkg;
  localparam int SAMPLE_W  = 16;
  localparam int COEF_W    = 16;
  localparam int COEF_FRAC = 14;
  localparam int ACC_W     = 36;

  typedef logic signed [SAMPLE_W-1:0] sample_t;
  typedef logic signed [COEF_W-1:0]   coef_t;

  localparam longint SMAX = (64'sd1 <<< (SAMPLE_W-1)) - 1;
  localparam longint SMIN = -(64'sd1 <<< (SAMPLE_W-1));

  function automatic sample_t sat_sample(input logic signed [63:0] v);
    if (v > SMAX)      return sample_t'(SMAX);
    else if (v < SMIN) return sample_t'(SMIN);
    else               return sample_t'(v);
  endfunction
endpackage

// File: rtl/carrier_sq.sv
module carrier_sq
  import carrier_rec_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    en_i,
  input  sample_t x_i,
  output sample_t sq_o
);
  localparam int PROD_W = 2 * SAMPLE_W;

  logic signed [PROD_W-1:0] prod;
  logic signed [63:0]       scaled;
  sample_t                  sq_q;

  assign prod   = x_i * x_i;
  assign scaled = 64'(prod) >>> (SAMPLE_W - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sq_q <= '0;
    else if (en_i) sq_q <= sat_sample(scaled);
  end

  assign sq_o = sq_q;

  p_sat_square_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && x_i == sample_t'(SMIN)) |=> (sq_o == sample_t'(SMAX)));
endmodule

// File: rtl/carrier_biquad.sv
module carrier_biquad
  import carrier_rec_pkg::*;
#(
  parameter coef_t B0 = 16'sd484,
  parameter coef_t B1 = 16'sd0,
  parameter coef_t B2 = -16'sd484,
  parameter coef_t A1 = -16'sd27853,
  parameter coef_t A2 = 16'sd15416
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    en_i,
  input  sample_t x_i,
  output sample_t y_o
);
  sample_t x1_q, x2_q, y1_q, y2_q;
  logic signed [ACC_W-1:0] acc;
  sample_t y_next;

  always_comb begin
    acc = ACC_W'(B0) * ACC_W'(x_i)
        + ACC_W'(B1) * ACC_W'(x1_q)
        + ACC_W'(B2) * ACC_W'(x2_q)
        - ACC_W'(A1) * ACC_W'(y1_q)
        - ACC_W'(A2) * ACC_W'(y2_q);
    y_next = sat_sample(64'(acc >>> COEF_FRAC));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x1_q <= '0;
      x2_q <= '0;
      y1_q <= '0;
      y2_q <= '0;
    end else if (en_i) begin
      x1_q <= x_i;
      x2_q <= x1_q;
      y1_q <= y_next;
      y2_q <= y1_q;
    end
  end

  assign y_o = y1_q;

  p_hold_stall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(y_o));
endmodule

// File: rtl/carrier_halver.sv
module carrier_halver
  import carrier_rec_pkg::*;
#(
  parameter int LEVEL = 16384
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    en_i,
  input  sample_t tone_i,
  output sample_t half_o
);
  localparam sample_t POS = sample_t'(LEVEL);
  localparam sample_t NEG = sample_t'(-LEVEL);

  sample_t prev_q;
  logic    flip_q;
  logic    rise;

  // rising zero crossing: negative before, non-negative now
  assign rise = (prev_q < 0) && (tone_i >= 0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      flip_q <= 1'b0;
    end else if (en_i) begin
      prev_q <= tone_i;
      if (rise) flip_q <= ~flip_q;
    end
  end

  assign half_o = flip_q ? NEG : POS;

  p_flip_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(half_o) |-> $past(en_i && (prev_q < 0) && (tone_i >= 0)));
endmodule

// File: rtl/carrier_recovery.sv
module carrier_recovery
  import carrier_rec_pkg::*;
#(
  parameter coef_t HI_B0 = 16'sd484,
  parameter coef_t HI_B1 = 16'sd0,
  parameter coef_t HI_B2 = -16'sd484,
  parameter coef_t HI_A1 = -16'sd27853,
  parameter coef_t HI_A2 = 16'sd15416,
  parameter coef_t LO_B0 = 16'sd484,
  parameter coef_t LO_B1 = 16'sd0,
  parameter coef_t LO_B2 = -16'sd484,
  parameter coef_t LO_A1 = -16'sd30786,
  parameter coef_t LO_A2 = 16'sd15416,
  parameter int    LEVEL = 16384
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [SAMPLE_W-1:0] carrier_o,
  output logic                valid_o
);
  localparam int LAT   = 4;
  localparam int CNT_W = $clog2(LAT + 1);

  sample_t sq, tone, half, carrier;
  logic [CNT_W-1:0] fill_q;

  carrier_sq u_sq (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .x_i   (sample_t'(sample_i)), .sq_o(sq)
  );

  carrier_biquad #(.B0(HI_B0), .B1(HI_B1), .B2(HI_B2), .A1(HI_A1), .A2(HI_A2)) u_res_hi (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .x_i(sq), .y_o(tone)
  );

  carrier_halver #(.LEVEL(LEVEL)) u_half (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .tone_i(tone), .half_o(half)
  );

  carrier_biquad #(.B0(LO_B0), .B1(LO_B1), .B2(LO_B2), .A1(LO_A1), .A2(LO_A2)) u_res_lo (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .x_i(half), .y_o(carrier)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               fill_q <= '0;
    else if (en_i && fill_q != CNT_W'(LAT))    fill_q <= fill_q + 1'b1;
  end

  assign valid_o   = (fill_q == CNT_W'(LAT));
  assign carrier_o = carrier;

  p_valid_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);
  p_valid_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(en_i));
  p_stall_out_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(carrier_o) && $stable(valid_o)));
endmodule

// File: tb/carrier_recovery_tb_top.sv
`timescale 1ns/1ps
module carrier_recovery_tb_top;
  localparam longint K_G   = 484;
  localparam longint K_HA1 = -27853;
  localparam longint K_LA1 = -30786;
  localparam longint K_A2  = 15416;
  localparam longint LVL   = 16384;
  localparam real    PI    = 3.14159265358979;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  logic [15:0] sample_i = '0;
  logic [15:0] carrier_o;
  logic valid_o;

  always #2.5 clk_i = ~clk_i;

  carrier_recovery dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .sample_i(sample_i),
    .carrier_o(carrier_o), .valid_o(valid_o)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reference model state
  longint m_sq, a_x1, a_x2, a_y, a_y2, m_prev, b_x1, b_x2, b_y, b_y2;
  bit     m_flip;
  int     m_fill;

  function automatic longint satv(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic model_clear();
    m_sq = 0; a_x1 = 0; a_x2 = 0; a_y = 0; a_y2 = 0; m_prev = 0;
    b_x1 = 0; b_x2 = 0; b_y = 0; b_y2 = 0; m_flip = 0; m_fill = 0;
  endtask

  task automatic model_step(input longint x);
    longint n_sq, n_a, n_b, h;
    bit n_flip;
    n_sq = satv((x * x) >>> 15);
    n_a  = satv((K_G * m_sq - K_G * a_x2 - K_HA1 * a_y - K_A2 * a_y2) >>> 14);
    h    = m_flip ? -LVL : LVL;
    n_flip = (m_prev < 0 && a_y >= 0) ? ~m_flip : m_flip;
    n_b  = satv((K_G * h - K_G * b_x2 - K_LA1 * b_y - K_A2 * b_y2) >>> 14);
    m_prev = a_y;
    a_x2 = a_x1; a_x1 = m_sq; a_y2 = a_y; a_y = n_a; m_sq = n_sq;
    m_flip = n_flip;
    b_x2 = b_x1; b_x1 = h; b_y2 = b_y; b_y = n_b;
    if (m_fill < 4) m_fill++;
  endtask

  // scoreboard
  longint q_car[$];
  bit     q_val[$];
  string  q_tag[$];
  bit     count_on = 0;
  int     rises = 0;
  longint last_car = 0;

  task automatic drive(input longint x, input bit en, input string tag);
    @(negedge clk_i);
    sample_i = 16'(x);
    en_i = en;
    if (en) model_step(x);
    q_car.push_back(b_y);
    q_val.push_back(m_fill == 4);
    q_tag.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk_i);
      #1;
      if (q_car.size() > 0) begin
        longint ec, ac;
        bit ev;
        string t;
        ec = q_car.pop_front();
        ev = q_val.pop_front();
        t  = q_tag.pop_front();
        ac = longint'($signed(carrier_o));
        chk(ac == ec, t, ac, ec);
        chk(valid_o == ev, "R6", longint'(valid_o), longint'(ev));
        if (count_on && last_car < 0 && ac >= 0) rises++;
        last_car = ac;
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  longint n = 0;
  longint sgn = 1;

  function automatic longint bpsk(input longint k, input longint s);
    return s * longint'($rtoi(20000.0 * $sin(2.0 * PI * real'(k) / 25.0)));
  endfunction

  initial begin : stim
    model_clear();
    #1;
    chk(carrier_o == 16'd0, "R1", longint'(carrier_o), 0);
    chk(valid_o == 1'b0, "R1", longint'(valid_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // fill and valid timing with a stall inside
    drive(1000, 1, "R6");
    drive(1000, 1, "R6");
    drive(1000, 0, "R2");
    drive(1000, 1, "R6");
    drive(1000, 1, "R6");

    // extreme inputs hit squarer saturation
    for (int i = 0; i < 40; i++)
      drive((i % 2) ? -32768 : 32767, 1, "R3");
    for (int i = 0; i < 20; i++) drive(-32768, 1, "R3");

    // modulated carrier with periodic stalls
    for (int i = 0; i < 2000; i++) begin
      if (n % 25 == 0) sgn = ($urandom % 2) ? 1 : -1;
      if (i % 37 == 5) drive(bpsk(n, sgn), 0, "R2");
      else begin
        drive(bpsk(n, sgn), 1, (i < 1000) ? "R4" : "R5");
        n++;
      end
    end

    // frequency of regenerated carrier
    count_on = 1;
    for (int i = 0; i < 500; i++) begin
      if (n % 25 == 0) sgn = ($urandom % 2) ? 1 : -1;
      drive(bpsk(n, sgn), 1, "R7");
      n++;
    end
    @(posedge clk_i); #2;
    count_on = 0;
    chk(rises >= 18 && rises <= 22, "R7", rises, 20);

    // asynchronous reset between edges
    @(posedge clk_i); #2;
    en_i = 1'b0;
    rst_ni = 1'b0;
    #0.5;
    chk(carrier_o == 16'd0, "R1", longint'($signed(carrier_o)), 0);
    chk(valid_o == 1'b0, "R1", longint'(valid_o), 0);
    model_clear();
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < 6; i++) drive(bpsk(n + i, 1), 1, "R6");
    for (int i = 0; i < 200; i++) begin
      drive(bpsk(n, 1), 1, "R4");
      n++;
    end

    @(posedge clk_i); #2;
    @(posedge clk_i); #2;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule